// File: doc/BRIEF.md
# DMA Channel Control and Status Register File

This block holds the software-visible control state of one descriptor-driven DMA channel: a control word, a status word, a current-descriptor pointer and a tail-descriptor pointer. Software reaches it through a single-cycle, 32-bit, word-addressed read/write port. The descriptor engine, the completion-interrupt counter and the delay timer are separate blocks. They take run, soft-reset, halted and idle state, a one-cycle start pulse and a counter-reload pulse from this block. They return event strobes, pointer advances and their live counter values.

The block handles several side effects. The soft-reset bit clears itself on the first read of control after it is set. The tail-pointer mode bit is always forced on. A write that sets run clears halted and idle. Interrupt flags are cleared by writing a one to them. A write to the tail pointer restarts an idle channel. The interrupt output combines the pending flags with the enables held in control.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, control reads 0x0001_0002 (completion threshold of one in bits 23:16, tail-pointer mode bit 1 set), status reads 0x0000_0001 (halted in bit 0) with zero live inputs, both pointers read 0, and run, soft-reset, idle, kick, reload and irq outputs are low.
- R2: Control bit 1 always reads 1, whatever value was written to it.
- R3: Writing control with bit 2 (soft reset) set drives soft_rst_o high and sets halted. The bit stays set across later control writes until the next control read, which returns it as 1 and clears it.
- R4: A control write with bit 0 (run) set while bit 2 is neither written nor pending clears halted and idle and raises reload_o for exactly one cycle. With reset pending, halted stays set and no reload pulse occurs.
- R5: Status bits 14:12 are flags set by evt_set[2:0] (bit 0 sets 12, bit 1 sets 13, bit 2 sets 14). Writing 1 to a flag bit clears it, and writing 0 leaves it. A set strobe in the same cycle as a clearing write wins.
- R6: A write to the tail pointer (word 4) stores the value, clears idle and raises kick_o for exactly the following cycle.
- R7: A status read (word 1) returns cnt_live in bits 23:16 and dly_live in bits 31:24 over the stored bits 15:0.
- R8: irq_o is high when any status flag in bits 14:12 has its matching control bit 14:12 set.
- R9: desc_adv loads desc_next into the current pointer (word 2). When the pointer being replaced equals the tail pointer, idle is set.
- R10: An evt_idle strobe sets idle (status bit 1).
- R11: Words other than 0, 1, 2 and 4 read as zero, and writes to them change no register.
- R12: Status writes do not change halted or idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as the access |
| cnt_live | input | 8 | Live completion counter value |
| dly_live | input | 8 | Live delay timer value |
| evt_set | input | 3 | Flag set strobes for status bits 14:12 |
| evt_idle | input | 1 | Engine reports idle |
| desc_adv | input | 1 | Engine advances the current pointer |
| desc_next | input | 32 | Next descriptor address |
| run_o | output | 1 | Run bit |
| soft_rst_o | output | 1 | Soft-reset pending |
| halted_o | output | 1 | Halted flag |
| idle_o | output | 1 | Idle flag |
| kick_o | output | 1 | Start pulse after a tail write |
| reload_o | output | 1 | Completion counter reload pulse |
| irq_o | output | 1 | Channel interrupt |
| cur_desc_o | output | 32 | Current descriptor pointer |
| tail_desc_o | output | 32 | Tail descriptor pointer |
| cmp_thresh_o | output | 8 | Completion threshold (control 23:16) |
| dly_cfg_o | output | 8 | Delay setting (control 31:24) |

## Verification
The hardest situations to reach are the collisions: a flag set strobe landing in the same cycle as the write that clears it, and a run request arriving while a soft reset is still pending. The bench drives both in a single cycle from its tasks. It writes run only after a soft-reset write and before any control read, then checks that halted holds and no reload pulse appears. Reaching idle through pointer advance needs a tail write, then a chain of advances until the replaced pointer matches the tail.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [7:0]        cnt_live,
  input  logic [7:0]        dly_live,
  input  logic [2:0]        evt_set,
  input  logic              evt_idle,
  input  logic              desc_adv,
  input  logic [31:0]       desc_next,
  output logic              run_o,
  output logic              soft_rst_o,
  output logic              halted_o,
  output logic              idle_o,
  output logic              kick_o,
  output logic              reload_o,
  output logic              irq_o,
  output logic [31:0]       cur_desc_o,
  output logic [31:0]       tail_desc_o,
  output logic [7:0]        cmp_thresh_o,
  output logic [7:0]        dly_cfg_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CUR  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_TAIL = ADDR_W'(4);
  localparam logic [31:0] CTRL_INIT = 32'h0001_0002;

  logic [31:0] ctrl_q, cur_q, tail_q;
  logic        halted_q, idle_q, kick_q, reload_q;
  logic [2:0]  flag_q;

  wire wr      = bus_en & bus_we;
  wire rd      = bus_en & ~bus_we;
  wire wr_ctrl = wr && bus_addr == A_CTRL;
  wire rd_ctrl = rd && bus_addr == A_CTRL;
  wire wr_stat = wr && bus_addr == A_STAT;
  wire wr_cur  = wr && bus_addr == A_CUR;
  wire wr_tail = wr && bus_addr == A_TAIL;

  wire soft_wr = wr_ctrl & bus_wdata[2];
  wire start   = wr_ctrl & bus_wdata[0] & ~(bus_wdata[2] | ctrl_q[2]);
  wire [2:0] clr = wr_stat ? bus_wdata[14:12] : 3'b000;

  wire [15:0] stat_lo = {1'b0, flag_q, 10'b0, idle_q, halted_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_INIT;
    end else if (wr_ctrl) begin
      ctrl_q <= bus_wdata | 32'h2 | {29'b0, ctrl_q[2], 2'b0};
    end else if (rd_ctrl) begin
      ctrl_q[2] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q <= 1'b1;
      idle_q   <= 1'b0;
      flag_q   <= 3'b000;
    end else if (soft_wr) begin
      halted_q <= 1'b1;
      idle_q   <= 1'b0;
      flag_q   <= 3'b000;
    end else begin
      if (start) halted_q <= 1'b0;
      if (start || wr_tail) idle_q <= 1'b0;
      else if (evt_idle || (desc_adv && !wr_cur && cur_q == tail_q)) idle_q <= 1'b1;
      flag_q <= (flag_q & ~clr) | evt_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q    <= '0;
      tail_q   <= '0;
      kick_q   <= 1'b0;
      reload_q <= 1'b0;
    end else begin
      if (wr_cur) cur_q <= bus_wdata;
      else if (desc_adv) cur_q <= desc_next;
      if (wr_tail) tail_q <= bus_wdata;
      kick_q   <= wr_tail;
      reload_q <= start;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (bus_addr)
        A_CTRL:  bus_rdata = ctrl_q;
        A_STAT:  bus_rdata = {dly_live, cnt_live, stat_lo};
        A_CUR:   bus_rdata = cur_q;
        A_TAIL:  bus_rdata = tail_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign run_o        = ctrl_q[0];
  assign soft_rst_o   = ctrl_q[2];
  assign halted_o     = halted_q;
  assign idle_o       = idle_q;
  assign kick_o       = kick_q;
  assign reload_o     = reload_q;
  assign irq_o        = |(flag_q & ctrl_q[14:12]);
  assign cur_desc_o   = cur_q;
  assign tail_desc_o  = tail_q;
  assign cmp_thresh_o = ctrl_q[23:16];
  assign dly_cfg_o    = ctrl_q[31:24];

  a_r6_kick_after_tail: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tail |=> kick_o && !idle_o);
  a_r3_read_clears_reset: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctrl |=> !soft_rst_o);
  a_r4_run_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[0] && !bus_wdata[2] && !soft_rst_o) |=> !halted_o && reload_o);
  a_r5_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[12] && !evt_set[0]) |=> !flag_q[0]);
  a_r9_pointer_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_adv && !wr_cur) |=> cur_desc_o == $past(desc_next));
  a_r12_status_keeps_halted: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !desc_adv && !evt_idle) |=> $stable(halted_o) && $stable(idle_o));
endmodule

// File: tb/sim_dma_chan_regs.sv
module sim_dma_chan_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [7:0]  cnt_live = '0, dly_live = '0;
  logic [2:0]  evt_set = '0;
  logic        evt_idle = 1'b0, desc_adv = 1'b0;
  logic [31:0] desc_next = '0;
  logic        run_o, soft_rst_o, halted_o, idle_o, kick_o, reload_o, irq_o;
  logic [31:0] cur_desc_o, tail_desc_o;
  logic [7:0]  cmp_thresh_o, dly_cfg_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dma_chan_regs #(.ADDR_W(4)) u0 (.*);

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_en = 0;
  endtask

  task automatic pulse_evt(logic [2:0] e);
    @(negedge clk); evt_set = e;
    @(negedge clk); evt_set = 0;
  endtask

  task automatic adv(logic [31:0] n);
    @(negedge clk); desc_adv = 1; desc_next = n;
    @(negedge clk); desc_adv = 0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(4'd0, v); chk("R1 ctrl", v, 32'h0001_0002);
    rd(4'd1, v); chk("R1 status", v, 32'h1);
    rd(4'd2, v); chk("R1 cur", v, 0);
    rd(4'd4, v); chk("R1 tail", v, 0);
    chk("R1 outs", {run_o, soft_rst_o, halted_o, idle_o, kick_o, reload_o, irq_o}, 7'b0010000);
  endtask

  task automatic t_tailmode;
    logic [31:0] v;
    wr(4'd0, 32'h0);
    rd(4'd0, v); chk("R2 mode bit forced", v, 32'h2);
    chk("R2 thresh", cmp_thresh_o, 0);
  endtask

  task automatic t_softrst;
    logic [31:0] v;
    wr(4'd0, 32'h1);
    chk("R4 halted cleared", halted_o, 0);
    chk("R4 reload pulse", reload_o, 1);
    @(negedge clk); chk("R4 reload one cycle", reload_o, 0);
    wr(4'd0, 32'h4);
    chk("R3 soft reset out", soft_rst_o, 1);
    chk("R3 halted set", halted_o, 1);
    wr(4'd0, 32'h1);
    chk("R4 run blocked halted", halted_o, 1);
    chk("R4 run blocked reload", reload_o, 0);
    chk("R3 reset retained", soft_rst_o, 1);
    rd(4'd0, v); chk("R3 read returns reset", v, 32'h7);
    chk("R3 cleared after read", soft_rst_o, 0);
    rd(4'd0, v); chk("R3 second read", v, 32'h3);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    pulse_evt(3'b111);
    rd(4'd1, v); chk("R5 flags set", v, 32'h7001);
    wr(4'd1, 32'h1000);
    rd(4'd1, v); chk("R5 w1c bit12", v, 32'h6001);
    wr(4'd1, 32'h0);
    rd(4'd1, v); chk("R12 status write keeps halted", v, 32'h6001);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = 4'd1; bus_wdata = 32'h2000; evt_set = 3'b010;
    @(negedge clk); bus_en = 0; bus_we = 0; evt_set = 0;
    rd(4'd1, v); chk("R5 set wins", v, 32'h6001);
    wr(4'd1, 32'h6000);
    rd(4'd1, v); chk("R5 all cleared", v, 32'h1);
  endtask

  task automatic t_irq;
    wr(4'd0, 32'h2000);
    chk("R8 idle irq", irq_o, 0);
    pulse_evt(3'b010);
    chk("R8 enabled flag", irq_o, 1);
    wr(4'd1, 32'h2000);
    chk("R8 cleared", irq_o, 0);
    pulse_evt(3'b001);
    chk("R8 masked flag", irq_o, 0);
    wr(4'd1, 32'h1000);
  endtask

  task automatic t_live;
    logic [31:0] v;
    cnt_live = 8'hA5; dly_live = 8'h3C;
    rd(4'd1, v); chk("R7 live fields", v, 32'h3CA5_0001);
    cnt_live = 0; dly_live = 0;
  endtask

  task automatic t_tail;
    logic [31:0] v;
    wr(4'd0, 32'h1);
    chk("R4 halted cleared again", halted_o, 0);
    @(negedge clk); evt_idle = 1;
    @(negedge clk); evt_idle = 0;
    chk("R10 idle set", idle_o, 1);
    wr(4'd4, 32'h100);
    chk("R6 idle cleared", idle_o, 0);
    chk("R6 kick", kick_o, 1);
    chk("R6 tail out", tail_desc_o, 32'h100);
    @(negedge clk); chk("R6 kick one cycle", kick_o, 0);
    rd(4'd4, v); chk("R6 tail read", v, 32'h100);
  endtask

  task automatic t_adv;
    logic [31:0] v;
    wr(4'd2, 32'h40);
    adv(32'h80);
    chk("R9 cur advanced", cur_desc_o, 32'h80);
    adv(32'h100);
    chk("R9 not at tail", idle_o, 0);
    adv(32'h140);
    chk("R9 idle at tail", idle_o, 1);
    rd(4'd2, v); chk("R9 cur read", v, 32'h140);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    wr(4'd3, 32'hFFFF_FFFF);
    rd(4'd3, v); chk("R11 word3 zero", v, 0);
    rd(4'd5, v); chk("R11 word5 zero", v, 0);
    rd(4'd0, v); chk("R11 ctrl unchanged", v, 32'h3);
    chk("R11 cur unchanged", cur_desc_o, 32'h140);
    chk("R11 idle unchanged", idle_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_tailmode;
    t_softrst;
    t_w1c;
    t_irq;
    t_live;
    t_tail;
    t_adv;
    t_unmapped;
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule